// File: doc/BRIEF.md
# Serial Audio Receive Sample Formatter

This block sits behind a serial digital audio decoder. The decoder hands it one subframe per strobe: a 24-bit audio word, the validity, user, channel-status and parity bits, a one-bit channel tag (0 = left, 1 = right) and a flag marking the first frame of a block. The formatter decides whether each sample is kept, checks its parity, cuts it to the configured width, orders its bytes and writes it into a 32-bit holding register. A bus master or DMA engine reads that register.

A 9-bit mode word configures the block. Bit 0 enables reception. Bit 1 gates on validity. Bit 2 selects big-endian byte order. Bit 3 turns the parity check off. Bits 5:4 hold the width code. Bit 7 selects packed output. Bit 8 discards block-start samples. Bit 6 is unused. Three outputs report events: a ready level, a one-cycle overrun pulse and a one-cycle parity-error pulse. Every output is registered. A subframe strobed in one clock cycle becomes visible just after the next rising edge.

Top module: `sprx_formatter`

## Requirements
- R1: While reset is held and directly after it, `rdyOut`, `ovrEvt` and `parEvt` are 0 and `holdData` is 0.
- R2: When mode bit 0 is 0, a strobed subframe changes nothing. `holdData` keeps its value, `rdyOut` does not rise, and neither event pulses, even when the parity is wrong. Clearing bit 0 also drops any held left half.
- R3: When mode bit 1 is 1, a subframe with validity bit 1 is not loaded and one with validity bit 0 is loaded. When bit 1 is 0, validity is ignored.
- R4: When mode bit 8 is 1, a subframe with the block-start flag set is not loaded. When bit 8 is 0, it is loaded like any other.
- R5: Parity is correct when the XOR of the 24 audio bits together with the validity, user, channel-status and parity bits is 0. With mode bit 3 at 0 and bit 0 at 1, a strobe with wrong parity pulses `parEvt` for one cycle after the edge, and the sample is still loaded if accepted. With bit 3 at 1, `parEvt` stays 0.
- R6: Width code 2 (and the reserved code 3) keeps all 24 bits. Code 1 keeps audio bits 23:4 and code 0 keeps bits 23:8. The result is right-justified and the upper bits are zero.
- R7: With mode bit 2 at 1, the sample's bytes are reversed. A 16-bit sample swaps its two bytes in bits 15:0. A 20- or 24-bit sample reverses its three bytes in bits 23:0.
- R8: A load sets `rdyOut`. A read strobe with no load in the same cycle clears it. A read together with a load leaves it at 1.
- R9: A load while `rdyOut` is 1 with no read in that cycle overwrites `holdData` and pulses `ovrEvt` for one cycle.
- R10: With mode bit 7 at 1 and width code 0, an accepted left sample is held back. The next accepted right sample loads `{right[15:0], left[15:0]}` and only then is ready raised. A second left sample replaces the held one.
- R11: Mode bit 7 has no effect unless the width code is 0.
- R12: In packed mode, an accepted right sample with no held left half is dropped without a load.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeCfg | input | 9 | Mode word (bit fields in the requirements) |
| subStrobe | input | 1 | One decoded subframe is present this cycle |
| subAudio | input | 24 | Audio word, bit 23 most significant |
| subV | input | 1 | Validity bit |
| subU | input | 1 | User bit |
| subC | input | 1 | Channel-status bit |
| subP | input | 1 | Parity bit |
| subChan | input | 1 | Channel tag, 0 left, 1 right |
| subBlkStart | input | 1 | Subframe opens a new block |
| rdStrobe | input | 1 | Holding register is read this cycle |
| holdData | output | 32 | Holding register |
| rdyOut | output | 1 | Unread sample present |
| ovrEvt | output | 1 | Overrun pulse |
| parEvt | output | 1 | Parity error pulse |

## Verification
A corrupted ready flag shows up one cycle after the next load or read. It appears as a missing or spurious `ovrEvt`, or as `rdyOut` failing to follow the read strobe. A stale held left half only shows on the next packed right sample: a pair is assembled from the wrong left data, or a right sample loads when it should have been dropped. The bench therefore checks all four outputs after every cycle against a running model, so any such divergence is caught in the cycle it surfaces.

// File: rtl/sprx_pkg.sv
package sprx_pkg;
  localparam int AUDIO_W = 24;
  localparam int HOLD_W  = 32;
  localparam int HALF_W  = HOLD_W / 2;
  localparam int MODE_W  = 9;
  localparam int BYTE_W  = 8;

  typedef enum logic [1:0] {
    WID16  = 2'd0,
    WID20  = 2'd1,
    WID24  = 2'd2,
    WIDRSV = 2'd3
  } widthCode_t;

  // mode word, bit 8 down to bit 0
  typedef struct packed {
    logic       blkDiscard;  // 8
    logic       packEn;      // 7
    logic       spare;       // 6
    widthCode_t width;       // 5:4
    logic       noParity;    // 3
    logic       bigEndian;   // 2
    logic       validGate;   // 1
    logic       rxEn;        // 0
  } modeBits_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeLeft;    // capture left half for packing
    logic loadHold;    // write holding register
    logic loadPacked;  // write holding register with pair
  } ctlStrobe_t;
endpackage

// File: rtl/sprx_control.sv
module sprx_control
  import sprx_pkg::*;
#(
  parameter int AW = AUDIO_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  modeBits_t     mode,
  input  logic          subStrobe,
  input  logic [AW-1:0] subAudio,
  input  logic          subV,
  input  logic          subU,
  input  logic          subC,
  input  logic          subP,
  input  logic          subChan,
  input  logic          subBlkStart,
  input  logic          rdStrobe,
  output ctlStrobe_t    ctl,
  output logic          rdyOut,
  output logic          ovrEvt,
  output logic          parEvt
);
  logic pendValid;
  logic rdyQ;
  logic packActive;
  logic accept;
  logic parBad;

  always_comb begin
    packActive = mode.packEn && (mode.width == WID16);
    accept     = subStrobe && mode.rxEn
                 && !(mode.validGate && subV)
                 && !(mode.blkDiscard && subBlkStart);
    parBad     = subStrobe && mode.rxEn && !mode.noParity
                 && (^{subAudio, subV, subU, subC, subP});
    ctl.takeLeft   = accept && packActive && !subChan;
    ctl.loadPacked = accept && packActive && subChan && pendValid;
    ctl.loadHold   = (accept && !packActive) || ctl.loadPacked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      rdyQ      <= 1'b0;
      ovrEvt    <= 1'b0;
      parEvt    <= 1'b0;
    end else begin
      if (!mode.rxEn)          pendValid <= 1'b0;
      else if (ctl.takeLeft)   pendValid <= 1'b1;
      else if (ctl.loadPacked) pendValid <= 1'b0;

      if (ctl.loadHold)   rdyQ <= 1'b1;
      else if (rdStrobe)  rdyQ <= 1'b0;

      ovrEvt <= ctl.loadHold && rdyQ && !rdStrobe;
      parEvt <= parBad;
    end
  end

  assign rdyOut = rdyQ;
endmodule

// File: rtl/sprx_datapath.sv
module sprx_datapath
  import sprx_pkg::*;
#(
  parameter int AW = AUDIO_W,
  parameter int HW = HOLD_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  widthCode_t    width,
  input  logic          bigEndian,
  input  logic [AW-1:0] subAudio,
  input  ctlStrobe_t    ctl,
  output logic [HW-1:0] holdData
);
  localparam int HALF   = HW / 2;
  localparam int SH20   = AW - 20;
  localparam int SH16   = AW - 16;
  localparam int NB16   = 2;
  localparam int NB24   = 3;

  logic [HW-1:0]   fitWord;
  logic [HW-1:0]   swap16;
  logic [HW-1:0]   swap24;
  logic [HW-1:0]   fmtWord;
  logic [HALF-1:0] pendHalf;
  logic [HW-1:0]   holdQ;

  // right-justify, keeping the most significant audio bits
  always_comb begin
    fitWord = '0;
    unique case (width)
      WID16:   fitWord[15:0] = subAudio[SH16 +: 16];
      WID20:   fitWord[19:0] = subAudio[SH20 +: 20];
      default: fitWord[AW-1:0] = subAudio;
    endcase
  end

  // byte reversal variants
  genvar gi;
  generate
    for (gi = 0; gi < NB16; gi++) begin : g_sw16
      assign swap16[gi*BYTE_W +: BYTE_W] = fitWord[(NB16-1-gi)*BYTE_W +: BYTE_W];
    end
    assign swap16[HW-1:NB16*BYTE_W] = '0;
    for (gi = 0; gi < NB24; gi++) begin : g_sw24
      assign swap24[gi*BYTE_W +: BYTE_W] = fitWord[(NB24-1-gi)*BYTE_W +: BYTE_W];
    end
    assign swap24[HW-1:NB24*BYTE_W] = '0;
  endgenerate

  always_comb begin
    if (!bigEndian)          fmtWord = fitWord;
    else if (width == WID16) fmtWord = swap16;
    else                     fmtWord = swap24;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendHalf <= '0;
      holdQ    <= '0;
    end else begin
      if (ctl.takeLeft) pendHalf <= fmtWord[HALF-1:0];
      if (ctl.loadPacked)    holdQ <= {fmtWord[HALF-1:0], pendHalf};
      else if (ctl.loadHold) holdQ <= fmtWord;
    end
  end

  assign holdData = holdQ;
endmodule

// File: rtl/sprx_formatter.sv
module sprx_formatter
  import sprx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [MODE_W-1:0]   modeCfg,
  input  logic                subStrobe,
  input  logic [AUDIO_W-1:0]  subAudio,
  input  logic                subV,
  input  logic                subU,
  input  logic                subC,
  input  logic                subP,
  input  logic                subChan,
  input  logic                subBlkStart,
  input  logic                rdStrobe,
  output logic [HOLD_W-1:0]   holdData,
  output logic                rdyOut,
  output logic                ovrEvt,
  output logic                parEvt
);
  modeBits_t  mode;
  ctlStrobe_t ctl;

  assign mode = modeBits_t'(modeCfg);

  sprx_control #(.AW(AUDIO_W)) u_ctl (
    .clk(clk), .rstN(rstN), .mode(mode),
    .subStrobe(subStrobe), .subAudio(subAudio),
    .subV(subV), .subU(subU), .subC(subC), .subP(subP),
    .subChan(subChan), .subBlkStart(subBlkStart),
    .rdStrobe(rdStrobe), .ctl(ctl),
    .rdyOut(rdyOut), .ovrEvt(ovrEvt), .parEvt(parEvt)
  );

  sprx_datapath #(.AW(AUDIO_W), .HW(HOLD_W)) u_dp (
    .clk(clk), .rstN(rstN), .width(mode.width),
    .bigEndian(mode.bigEndian), .subAudio(subAudio),
    .ctl(ctl), .holdData(holdData)
  );
endmodule

// File: rtl/sprx_checker.sv
module sprx_checker
  import sprx_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [MODE_W-1:0]  modeCfg,
  input logic               subStrobe,
  input logic               subV,
  input logic               subBlkStart,
  input logic               rdStrobe,
  input logic [HOLD_W-1:0]  holdData,
  input logic               rdyOut,
  input logic               ovrEvt,
  input logic               parEvt
);
  a_r2_no_events_off: assert property (@(posedge clk) disable iff (!rstN)
    !modeCfg[0] |=> (!ovrEvt && !parEvt));

  a_r2_hold_stable_off: assert property (@(posedge clk) disable iff (!rstN)
    !modeCfg[0] |=> $stable(holdData));

  a_r3_invalid_kept_out: assert property (@(posedge clk) disable iff (!rstN)
    (subStrobe && modeCfg[1] && subV) |=> $stable(holdData));

  a_r4_block_start_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (subStrobe && modeCfg[8] && subBlkStart) |=> $stable(holdData));

  a_r5_parity_check_off: assert property (@(posedge clk) disable iff (!rstN)
    modeCfg[3] |=> !parEvt);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !subStrobe) |=> !rdyOut);

  a_r9_overrun_when_full: assert property (@(posedge clk) disable iff (!rstN)
    ovrEvt |-> (rdyOut && $past(rdyOut)));
endmodule

bind sprx_formatter sprx_checker u_chk (.*);

// File: tb/sprx_formatter_test.sv
module sprx_formatter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  modeCfg = '0;
  logic        subStrobe = 1'b0;
  logic [23:0] subAudio = '0;
  logic        subV = 1'b0, subU = 1'b0, subC = 1'b0, subP = 1'b0;
  logic        subChan = 1'b0, subBlkStart = 1'b0, rdStrobe = 1'b0;
  logic [31:0] holdData;
  logic        rdyOut, ovrEvt, parEvt;

  int nRun = 0;
  int nFail = 0;

  logic        mRdy = 1'b0;
  logic [31:0] mHold = '0;
  logic        mPendV = 1'b0;
  logic [15:0] mPend = '0;

  sprx_formatter uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog expired (R1 run incomplete) actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  function automatic logic [8:0] mk(input bit en, input bit vg, input bit big,
      input bit nop, input bit [1:0] wc, input bit pk, input bit blk);
    return {blk, pk, 1'b0, wc, nop, big, vg, en};
  endfunction

  function automatic logic [31:0] expFmt(input logic [23:0] a,
      input logic [1:0] wc, input logic big);
    logic [31:0] w;
    w = '0;
    if (wc == 2'd0) w[15:0] = a[23:8];
    else if (wc == 2'd1) w[19:0] = a[23:4];
    else w[23:0] = a;
    if (big) begin
      if (wc == 2'd0) w = {16'h0, w[7:0], w[15:8]};
      else            w = {8'h0, w[7:0], w[15:8], w[23:16]};
    end
    return w;
  endfunction

  task automatic check(input string tag, input logic eRdy, input logic [31:0] eHold,
      input logic eOvr, input logic ePar);
    nRun++;
    if (rdyOut !== eRdy || holdData !== eHold || ovrEvt !== eOvr || parEvt !== ePar) begin
      nFail++;
      $display("FAIL %s: rdy=%0b/%0b hold=%h/%h ovr=%0b/%0b par=%0b/%0b (actual/expected)",
               tag, rdyOut, eRdy, holdData, eHold, ovrEvt, eOvr, parEvt, ePar);
    end
  endtask

  // one clock cycle: drive, predict, sample after the edge
  task automatic step(input bit stb, input logic [23:0] a, input bit v,
      input bit blk, input bit ch, input bit badPar, input bit rd, input string tag);
    logic en, load, eOvr, ePar, packAct, acc;
    logic [31:0] f, word;
    @(negedge clk);
    subStrobe = stb; subAudio = a; subV = v; subU = a[3]; subC = a[11];
    subP = (^{a, v, a[3], a[11]}) ^ badPar;
    subChan = ch; subBlkStart = blk; rdStrobe = rd;
    en = modeCfg[0];
    load = 1'b0; word = '0; ePar = 1'b0;
    packAct = modeCfg[7] && (modeCfg[5:4] == 2'd0);
    f = expFmt(a, modeCfg[5:4], modeCfg[2]);
    if (stb && en) begin
      ePar = !modeCfg[3] && badPar;
      acc = !(modeCfg[1] && v) && !(modeCfg[8] && blk);
      if (acc) begin
        if (!packAct) begin load = 1'b1; word = f; end
        else if (!ch) begin mPend = f[15:0]; mPendV = 1'b1; end
        else if (mPendV) begin load = 1'b1; word = {f[15:0], mPend}; mPendV = 1'b0; end
      end
    end
    if (!en) mPendV = 1'b0;
    eOvr = load && mRdy && !rd;
    if (load) begin mRdy = 1'b1; mHold = word; end
    else if (rd) mRdy = 1'b0;
    @(posedge clk);
    #1;
    check(tag, mRdy, mHold, eOvr, ePar);
  endtask

  task automatic idle(input bit rd, input string tag);
    step(1'b0, 24'h0, 1'b0, 1'b0, 1'b0, 1'b0, rd, tag);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5A17);
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset held", 1'b0, 32'h0, 1'b0, 1'b0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", 1'b0, 32'h0, 1'b0, 1'b0);

    // R6 widths, little-endian
    modeCfg = mk(1,0,0,0,2'd2,0,0);
    step(1, 24'hABCDEF, 0, 0, 0, 0, 0, "R6 24-bit");
    idle(1, "R8 read clears ready");
    modeCfg = mk(1,0,0,0,2'd1,0,0);
    step(1, 24'h123456, 0, 0, 1, 0, 1, "R6 20-bit");
    modeCfg = mk(1,0,0,0,2'd0,0,0);
    step(1, 24'hFEDCBA, 0, 0, 0, 0, 0, "R9 overrun 16-bit");
    modeCfg = mk(1,0,0,0,2'd3,0,0);
    step(1, 24'h010203, 0, 0, 0, 0, 1, "R8 read with load, R6 reserved code");
    idle(1, "R8 clear");

    // R7 byte order
    modeCfg = mk(1,0,1,0,2'd2,0,0);
    step(1, 24'h112233, 0, 0, 0, 0, 1, "R7 big 24");
    modeCfg = mk(1,0,1,0,2'd0,0,0);
    step(1, 24'hA1B2C3, 0, 0, 0, 0, 1, "R7 big 16");
    modeCfg = mk(1,0,1,0,2'd1,0,0);
    step(1, 24'hA1B2C3, 0, 0, 0, 0, 1, "R7 big 20");

    // R2 disabled
    modeCfg = mk(0,0,0,0,2'd2,0,0);
    step(1, 24'h777777, 0, 0, 0, 1, 0, "R2 disabled");

    // R3 validity gate
    modeCfg = mk(1,1,0,0,2'd2,0,0);
    step(1, 24'h333333, 1, 0, 0, 0, 1, "R3 invalid dropped");
    step(1, 24'h444444, 0, 0, 0, 0, 1, "R3 valid loaded");
    modeCfg = mk(1,0,0,0,2'd2,0,0);
    step(1, 24'h454545, 1, 0, 0, 0, 1, "R3 gate off");

    // R4 block start
    modeCfg = mk(1,0,0,0,2'd2,0,1);
    step(1, 24'h555555, 0, 1, 0, 0, 1, "R4 block start dropped");
    modeCfg = mk(1,0,0,0,2'd2,0,0);
    step(1, 24'h565656, 0, 1, 0, 0, 1, "R4 block start kept");

    // R5 parity
    step(1, 24'h666666, 0, 0, 0, 1, 1, "R5 bad parity flagged");
    modeCfg = mk(1,0,0,1,2'd2,0,0);
    step(1, 24'h676767, 0, 0, 0, 1, 1, "R5 check off");

    // R10 / R12 packing
    modeCfg = mk(1,0,0,0,2'd0,1,0);
    step(1, 24'hCAFE00, 0, 0, 1, 0, 1, "R12 orphan right dropped");
    step(1, 24'h111100, 0, 0, 0, 0, 1, "R10 left held");
    step(1, 24'h222200, 0, 0, 0, 0, 1, "R10 left replaced");
    step(1, 24'h333300, 0, 0, 1, 0, 0, "R10 pair loaded");
    idle(1, "R10 read");
    step(1, 24'h999900, 0, 0, 0, 0, 0, "R2 pending before disable");
    modeCfg = mk(0,0,0,0,2'd0,1,0);
    idle(0, "R2 disable drops held half");
    modeCfg = mk(1,0,0,0,2'd0,1,0);
    step(1, 24'h888800, 0, 0, 1, 0, 0, "R12 right after disable dropped");

    // R11 pack ignored at 24 bits
    modeCfg = mk(1,0,0,0,2'd2,1,0);
    step(1, 24'h123123, 0, 0, 0, 0, 1, "R11 pack ignored");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (i % 40 == 0)
        modeCfg = {r[8:7], 1'b0, r[5:4], r[3:1], (r[10:9] != 2'b00)};
      step(r[11] | r[12], $urandom, r[13] & r[14], r[15] & r[16], r[17],
           r[18] & r[19] & r[20], r[21] | r[22], "R9/R10 random mix");
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule